// File: doc/BRIEF.md
# Bus-Commanded Six-Channel Audio Routing Controller

This block is the control side of a six-channel audio switch. An external controller writes to it over a two-wire I2C bus, and the block only receives. It samples SCL and SDA with the system clock and cleans them up. It frames START and STOP conditions and accepts write transfers sent to one fixed 7-bit device address. Once the address byte has been acknowledged, any number of single-byte commands may follow before the STOP, and each command is acknowledged and acted on by itself.

The upper nibble of a command chooses its kind. The kinds set the input source, mute one output channel or all of them, switch surround enhancement on or off, or set the gain of the mixed channel. The block holds the resulting settings in registers and drives them out as levels for the analog switch fabric. An extra output carries the surround enable that actually applies, which is forced low while the direct six-channel input is routed.

The system clock must run at least 20 times the bus bit rate, and the bus runs at up to 100 kbit/s. SDA is open-drain, and `sda_pull_o` asks the pad to pull the line low.

Top module: `audio_route_ctrl`

## Requirements
- R1: After reset all six mute bits are 1, the source code is 0 (stereo group 1), surround enable, effective surround and mix boost are 0, and `sda_pull_o` is 0.
- R2: A transfer whose first byte after START is 8'b1001_0100 (address 7'h4A, write) is acknowledged: `sda_pull_o` is 1 throughout the high phase of the ninth clock.
- R3: Any other first byte, including the same address with the read bit set, is not acknowledged. Later bytes get no acknowledge and change nothing until the next START.
- R4: Several data bytes may follow one address. Each is acknowledged and applied by itself, and a register changes only in the cycle in which the acknowledge for its byte begins.
- R5: Byte 1111_fff_M sets one mute bit to M, where 1 means muted. fff=000..101 selects `mute_o` bit 0..5 (front-left, front-right, center, sub, rear-left, rear-right).
- R6: Byte 1111_111_M sets all six mute bits to M.
- R7: Byte 1100_cccc selects the source. cccc=1011 gives `src_sel_o`=0 (group 1), 1010 gives 1, 1001 gives 2, 1000 gives 3, and 0111 gives 4 (direct six-channel). `src_sel_o` never exceeds 4.
- R8: Byte 1101_000x sets surround enable to the inverse of x (x=0 on, x=1 off).
- R9: Byte 1001_000x sets `mix_boost_o` to x (0 gives 0 dB, 1 gives +6 dB).
- R10: `surround_eff_o` is 1 only when surround enable is 1 and `src_sel_o` is not 4.
- R11: A data byte that matches no pattern, including 1111_110_M and unlisted 1100 codes, is acknowledged but changes no output.
- R12: A START or STOP that arrives before the eighth bit of a byte is complete discards that byte and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_pull_o | output | 1 | Pull-low request for the open-drain SDA pad |
| src_sel_o | output | 3 | Source code: 0..3 stereo group 1..4, 4 direct six-channel |
| mute_o | output | 6 | Per-channel mute, bit 0 FL, 1 FR, 2 CT, 3 SUB, 4 SL, 5 SR |
| surround_en_o | output | 1 | Stored surround enable |
| surround_eff_o | output | 1 | Surround enable that applies to the current source |
| mix_boost_o | output | 1 | Mixed-channel gain, 1 selects +6 dB |

## Verification
Every pad edge takes the synchronizer depth plus the filter length plus one register to reach the framing logic, which is six clocks at the default settings. Because of that delay, the acknowledge pull and a decoded register update both land six clocks after the SCL fall that ends the eighth bit. The bench holds each bus phase for 25 clocks, so it samples the acknowledge in the middle of the ninth clock's high phase and well inside the window. After each transfer the driver waits 20 clocks past the STOP before it pushes the expected settings. The monitor compares them when it pops, so the comparison always falls after the last possible update.

// File: rtl/arc_pkg.sv
// Shared types and constants for the audio routing controller.
package arc_pkg;
    // Number of output channels that carry a mute bit.
    localparam int NUM_CH = 6;

    // Framing states of the bus receiver.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK,
        RX_SKIP
    } rx_state_t;

    // Source selection codes driven on src_sel_o.
    typedef enum logic [2:0] {
        SRC_GRP1  = 3'd0,
        SRC_GRP2  = 3'd1,
        SRC_GRP3  = 3'd2,
        SRC_GRP4  = 3'd3,
        SRC_MULTI = 3'd4
    } src_t;

    // Command classes, taken from the upper nibble of a data byte.
    localparam logic [3:0] OP_MUTE   = 4'hF;
    localparam logic [3:0] OP_SOURCE = 4'hC;
    localparam logic [3:0] OP_SURR   = 4'hD;
    localparam logic [3:0] OP_MIX    = 4'h9;
endpackage

// File: rtl/arc_line_filter.sv
// arc_line_filter: brings one open-drain bus line into the clock domain.
// It uses a SYNC_STAGES flop synchronizer and then a majority-free filter
// that changes its output only after FILT_LEN equal samples in a row.
// It reports one-cycle rise and fall strobes of the filtered level.
// Assumes: the line idles high, and the pulses to reject are shorter
// than FILT_LEN clocks.
module arc_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam logic [FILT_LEN-1:0] ALL_HI = '1;
    localparam logic [FILT_LEN-1:0] ALL_LO = '0;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   level_q;
    logic                   level_d1_q;

    // Synchronizer chain, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Sample history used to decide whether the line has settled.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= ALL_HI;
        else        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Filtered level: it moves only on a run of identical samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                 level_q <= 1'b1;
        else if (hist_q == ALL_HI)  level_q <= 1'b1;
        else if (hist_q == ALL_LO)  level_q <= 1'b0;
    end

    // Delayed copy of the level, kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d1_q <= 1'b1;
        else        level_d1_q <= level_q;
    end

    assign level_o = level_q;
    assign rise_o  = level_q & ~level_d1_q;
    assign fall_o  = ~level_q & level_d1_q;
endmodule

// File: rtl/arc_rx_fsm.sv
// arc_rx_fsm: write-only bus slave framing. It finds START and STOP,
// shifts bytes in MSB first, checks the address byte and drives the
// acknowledge. It emits a strobe for each complete data byte.
// Assumes: filtered, synchronous SCL/SDA levels and edge strobes, and
// SDA edges while SCL is high only as START or STOP.
module arc_rx_fsm
    import arc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h4A,
    parameter int         BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl,
    input  logic                 sda,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda_rise,
    input  logic                 sda_fall,
    output logic                 byte_stb,
    output logic [BYTE_BITS-1:0] byte_data,
    output logic                 pull_o
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0]     FULL_CNT   = CNT_W'(BYTE_BITS);
    localparam logic [BYTE_BITS-1:0] ADDR_WRITE = {DEV_ADDR, 1'b0};

    rx_state_t            state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_BITS-1:0] shreg_q;
    logic                 pull_q;
    logic                 bus_start;
    logic                 bus_stop;
    logic                 byte_end;

    // Bus conditions: an SDA edge while SCL stays high.
    assign bus_start = sda_fall & scl;
    assign bus_stop  = sda_rise & scl;
    // The SCL fall after the eighth bit closes a byte.
    assign byte_end  = scl_fall & (cnt_q == FULL_CNT) & ~bus_start & ~bus_stop;

    // Framing state machine together with the bit shifter and the ack drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            pull_q  <= 1'b0;
        end else if (bus_start) begin
            state_q <= RX_ADDR;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else if (bus_stop) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
        end else begin
            unique case (state_q)
                RX_ADDR, RX_DATA: begin
                    if (scl_rise && cnt_q != FULL_CNT) begin
                        shreg_q <= {shreg_q[BYTE_BITS-2:0], sda};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (byte_end) begin
                        cnt_q <= '0;
                        if (state_q == RX_DATA) begin
                            state_q <= RX_DATA_ACK;
                            pull_q  <= 1'b1;
                        end else if (shreg_q == ADDR_WRITE) begin
                            state_q <= RX_ADDR_ACK;
                            pull_q  <= 1'b1;
                        end else begin
                            state_q <= RX_SKIP;
                        end
                    end
                end
                RX_ADDR_ACK, RX_DATA_ACK: begin
                    if (scl_fall) begin
                        state_q <= RX_DATA;
                        pull_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign byte_stb  = (state_q == RX_DATA) & byte_end;
    assign byte_data = shreg_q;
    assign pull_o    = pull_q;
endmodule

// File: rtl/arc_cmd_decode.sv
// arc_cmd_decode: turns each accepted command byte into the routing
// registers: source, per-channel mutes, surround enable and mix gain.
// Bytes that match no pattern leave every register as it is.
// Assumes: byte_stb is a one-cycle pulse with byte_data valid at it.
module arc_cmd_decode
    import arc_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_stb,
    input  logic [7:0]      byte_data,
    output logic [2:0]      src_sel_o,
    output logic [N_CH-1:0] mute_o,
    output logic            surround_en_o,
    output logic            surround_eff_o,
    output logic            mix_boost_o
);
    localparam logic [2:0] ALL_FIELD = 3'b111;

    logic [3:0] opcode;
    logic [2:0] mute_field;
    logic       is_mute;
    logic       src_hit;
    src_t       src_new;
    src_t       src_q;
    logic       surr_q;
    logic       mix_q;

    assign opcode     = byte_data[7:4];
    assign mute_field = byte_data[3:1];
    assign is_mute    = byte_stb & (opcode == OP_MUTE);

    // Source code lookup; unlisted codes raise no hit.
    always_comb begin
        src_hit = 1'b1;
        src_new = SRC_GRP1;
        unique case (byte_data[3:0])
            4'b1011: src_new = SRC_GRP1;
            4'b1010: src_new = SRC_GRP2;
            4'b1001: src_new = SRC_GRP3;
            4'b1000: src_new = SRC_GRP4;
            4'b0111: src_new = SRC_MULTI;
            default: src_hit = 1'b0;
        endcase
    end

    // Source register, loaded only by a valid source command.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         src_q <= SRC_GRP1;
        else if (byte_stb && opcode == OP_SOURCE && src_hit) src_q <= src_new;
    end

    // One mute flop per channel, hit by its own field or by the all-channel field.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_mute
        always_ff @(posedge clk) begin
            if (!rst_n)
                mute_o[ch] <= 1'b1;
            else if (is_mute && (mute_field == 3'(ch) || mute_field == ALL_FIELD))
                mute_o[ch] <= byte_data[0];
        end
    end

    // Surround enable: a clear LSB turns it on.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          surr_q <= 1'b0;
        else if (byte_stb && byte_data[7:1] == {OP_SURR, 3'b000}) surr_q <= ~byte_data[0];
    end

    // Mixed-channel gain: a set LSB selects the boost.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         mix_q <= 1'b0;
        else if (byte_stb && byte_data[7:1] == {OP_MIX, 3'b000}) mix_q <= byte_data[0];
    end

    assign src_sel_o      = src_q;
    assign surround_en_o  = surr_q;
    assign surround_eff_o = surr_q & (src_q != SRC_MULTI);
    assign mix_boost_o    = mix_q;
endmodule

// File: rtl/audio_route_ctrl.sv
// audio_route_ctrl: top of the bus-commanded audio routing controller.
// It filters the two bus lines, frames write transfers to DEV_ADDR and
// decodes each data byte into the routing control registers.
// Assumes: clk runs at least 20x the bus bit rate, and SDA is open-drain
// with the pad pulling low whenever sda_pull_o is 1.
module audio_route_ctrl
    import arc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4A,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [2:0]        src_sel_o,
    output logic [NUM_CH-1:0] mute_o,
    output logic              surround_en_o,
    output logic              surround_eff_o,
    output logic              mix_boost_o
);
    localparam int N_LINES = 2; // index 0 = SCL, 1 = SDA

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;
    logic               byte_stb;
    logic [7:0]         byte_data;

    assign raw_lines = {sda_i, scl_i};

    // The same conditioning path is used for each bus line.
    for (genvar ln = 0; ln < N_LINES; ln++) begin : g_line
        arc_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_lines[ln]),
            .level_o (lvl[ln]),
            .rise_o  (rise[ln]),
            .fall_o  (fall[ln])
        );
    end

    arc_rx_fsm #(
        .DEV_ADDR  (DEV_ADDR),
        .BYTE_BITS (8)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (lvl[0]),
        .sda       (lvl[1]),
        .scl_rise  (rise[0]),
        .scl_fall  (fall[0]),
        .sda_rise  (rise[1]),
        .sda_fall  (fall[1]),
        .byte_stb  (byte_stb),
        .byte_data (byte_data),
        .pull_o    (sda_pull_o)
    );

    arc_cmd_decode #(
        .N_CH (NUM_CH)
    ) u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .byte_stb       (byte_stb),
        .byte_data      (byte_data),
        .src_sel_o      (src_sel_o),
        .mute_o         (mute_o),
        .surround_en_o  (surround_en_o),
        .surround_eff_o (surround_eff_o),
        .mix_boost_o    (mix_boost_o)
    );
endmodule

// File: rtl/arc_chk.sv
// arc_chk: property checks on the routing controller's ports, bound to
// every instance of audio_route_ctrl.
module arc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull_o,
    input logic [2:0] src_sel_o,
    input logic [5:0] mute_o,
    input logic       surround_en_o,
    input logic       surround_eff_o,
    input logic       mix_boost_o
);
    logic was_in_reset_q;

    // Remembers whether the previous cycle was in reset.
    always_ff @(posedge clk) begin
        was_in_reset_q <= !rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_n && was_in_reset_q) begin
            reset_state_chk: assert (mute_o == 6'h3F && src_sel_o == 3'd0 &&
                                     !surround_en_o && !mix_boost_o && !sda_pull_o)
                else $error("reset_state_chk");
        end
    end

    // R7
    src_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_o <= 3'd4);

    // R10
    eff_surround_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_o == 3'd4) |-> !surround_eff_o);

    // R10
    eff_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        surround_eff_o |-> surround_en_o);

    // R4
    update_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({src_sel_o, mute_o, surround_en_o, mix_boost_o}) |-> $rose(sda_pull_o));
endmodule

bind audio_route_ctrl arc_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sda_pull_o     (sda_pull_o),
    .src_sel_o      (src_sel_o),
    .mute_o         (mute_o),
    .surround_en_o  (surround_en_o),
    .surround_eff_o (surround_eff_o),
    .mix_boost_o    (mix_boost_o)
);

// File: tb/audio_route_ctrl_tb.sv
// Scoreboard bench: the driver keeps a model of the settings and queues
// snapshots of it, and a monitor pops them and compares the outputs.
module audio_route_ctrl_tb;
    localparam int Q        = 25;   // clocks per bus quarter phase
    localparam int SETTLE   = 20;
    localparam int WATCHDOG = 150000;

    typedef struct {
        logic [2:0] src;
        logic [5:0] mute;
        logic       sur;
        logic       eff;
        logic       mix;
        string      tag;
    } snap_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_line;
    logic       sda_pull_o;
    logic [2:0] src_sel_o;
    logic [5:0] mute_o;
    logic       surround_en_o;
    logic       surround_eff_o;
    logic       mix_boost_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    snap_t exp_q[$];

    logic [2:0] m_src = 3'd0;
    logic [5:0] m_mute = 6'h3F;
    logic       m_sur = 1'b0;
    logic       m_mix = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull_o;

    audio_route_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_drv),
        .sda_i          (sda_line),
        .sda_pull_o     (sda_pull_o),
        .src_sel_o      (src_sel_o),
        .mute_o         (mute_o),
        .surround_en_o  (surround_en_o),
        .surround_eff_o (surround_eff_o),
        .mix_boost_o    (mix_boost_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    // Applies one command byte to the bench's model of the settings.
    task automatic model_cmd(input logic [7:0] b);
        if (b[7:4] == 4'hF) begin
            if (b[3:1] == 3'b111)     m_mute = {6{b[0]}};
            else if (b[3:1] <= 3'd5)  m_mute[b[3:1]] = b[0];
        end else if (b[7:4] == 4'hC) begin
            case (b[3:0])
                4'hB: m_src = 3'd0;
                4'hA: m_src = 3'd1;
                4'h9: m_src = 3'd2;
                4'h8: m_src = 3'd3;
                4'h7: m_src = 3'd4;
                default: ;
            endcase
        end else if (b[7:1] == 7'b1101_000) begin
            m_sur = ~b[0];
        end else if (b[7:1] == 7'b1001_000) begin
            m_mix = b[0];
        end
    endtask

    task automatic push_exp(input string tag);
        snap_t s;
        s.src  = m_src;
        s.mute = m_mute;
        s.sur  = m_sur;
        s.eff  = m_sur && (m_src != 3'd4);
        s.mix  = m_mix;
        s.tag  = tag;
        exp_q.push_back(s);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q();
        scl_drv = 1'b1; wait_q();
        sda_drv = 1'b0; wait_q();
        scl_drv = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q();
        scl_drv = 1'b1; wait_q();
        sda_drv = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b;    wait_q();
        scl_drv = 1'b1; wait_q(); wait_q();
        scl_drv = 1'b0; wait_q();
    endtask

    // Sends a byte and checks the acknowledge in the middle of the ninth high phase.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic ack;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_drv = 1'b1; wait_q();
        scl_drv = 1'b1; wait_q();
        ack = sda_pull_o;
        wait_q();
        scl_drv = 1'b0; wait_q();
        check(ack == exp_ack, tag, ack, exp_ack);
        if (exp_ack) model_cmd(b);
    endtask

    task automatic settle_and_push(input string tag);
        repeat (SETTLE) @(negedge clk);
        push_exp(tag);
        repeat (2) @(negedge clk);
    endtask

    // Complete write: address, data bytes, stop, then queue the expected state.
    task automatic write_cmds(input logic [7:0] cmds[], input string tag);
        bus_start();
        send_byte(8'h94, 1'b1, "R2 address ack");
        foreach (cmds[i]) send_byte(cmds[i], 1'b1, {tag, " R4 data ack"});
        bus_stop();
        settle_and_push(tag);
    endtask

    // Monitor: pops each expected snapshot and compares it with the outputs.
    initial begin
        snap_t s;
        forever begin
            wait (exp_q.size() > 0);
            s = exp_q.pop_front();
            check(src_sel_o == s.src, {s.tag, " src"}, src_sel_o, s.src);
            check(mute_o == s.mute, {s.tag, " mute"}, mute_o, s.mute);
            check(surround_en_o == s.sur, {s.tag, " surround"}, surround_en_o, s.sur);
            check(surround_eff_o == s.eff, {s.tag, " R10 effective"}, surround_eff_o, s.eff);
            check(mix_boost_o == s.mix, {s.tag, " mix"}, mix_boost_o, s.mix);
        end
    end

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sda_pull_o == 1'b0, "R1 pull idle", sda_pull_o, 0);
        push_exp("R1");
        @(negedge clk);

        // R5 individual unmutes, several bytes per transfer (R4)
        write_cmds('{8'hF0, 8'hF2, 8'hF4}, "R5 unmute FL FR CT");
        write_cmds('{8'hF6, 8'hF8, 8'hFA, 8'hF5}, "R5 unmute rest, mute CT");

        // R7 six-channel input, then R8 surround on: effective stays low (R10)
        write_cmds('{8'hC7, 8'hD0}, "R10 six-ch gate");
        write_cmds('{8'hC9}, "R7 group3 R8 surround");
        write_cmds('{8'hD1, 8'hC8}, "R8 surround off R7 group4");
        write_cmds('{8'hCA}, "R7 group2");
        write_cmds('{8'hD0, 8'hCB}, "R7 group1 R8");

        // R9 mix gain
        write_cmds('{8'h91}, "R9 boost");
        write_cmds('{8'h90}, "R9 flat");

        // R6 global mute and unmute
        write_cmds('{8'hFF}, "R6 all mute");
        write_cmds('{8'hFE}, "R6 all unmute");

        // R11 unmatched bytes acked, no change
        write_cmds('{8'h55, 8'hFC, 8'hC0, 8'h92, 8'hD2}, "R11 unmatched");

        // R3 wrong address: no ack, following byte ignored
        bus_start();
        send_byte(8'h96, 1'b0, "R3 wrong address");
        send_byte(8'hFF, 1'b0, "R3 byte after wrong address");
        bus_stop();
        settle_and_push("R3 wrong address no change");

        // R3 read direction
        bus_start();
        send_byte(8'h95, 1'b0, "R3 read bit");
        send_byte(8'hC7, 1'b0, "R3 byte after read address");
        bus_stop();
        settle_and_push("R3 read no change");

        // R12 STOP in mid byte
        bus_start();
        send_byte(8'h94, 1'b1, "R2 address ack");
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        settle_and_push("R12 stop mid byte");

        // R12 repeated START in mid byte, then a full command
        bus_start();
        send_byte(8'h94, 1'b1, "R2 address ack");
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(8'h94, 1'b1, "R12 address after restart");
        send_byte(8'hF3, 1'b1, "R12 command after restart");
        bus_stop();
        settle_and_push("R12 restart mid byte");

        repeat (10) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule